// File: doc/BRIEF.md
# In-band Xon/Xoff Flow Controller

This block carries out character-based flow control for a single serial channel. It watches every character that the receiver delivers and compares it with four programmable values: two that stop the local transmitter and two that start it again. A stop or start pattern is either one character or two characters received back to back. A stop pattern does not cut off a character already on the line. The transmitter is held only once the serializer reports that it is between characters.

In the other direction, the block watches how full the local receive FIFO is. It asks the serializer to send a stop character when occupancy climbs to an upper mark, and a start character when occupancy later drains to a lower mark. A four-way trigger selector picks both marks. A strobe marks each received character that completed an acted-on match, so the FIFO can decide not to store it. An interrupt flag records that the far end stopped the transmitter.

Top module: `xflow_ctrl`

## Requirements
- R1: After reset, `tx_allow` is 1, `send_stop` and `send_start` are 0, `stop_irq` is 0 and any partial two-character match is forgotten.
- R2: In single mode (`pair_mode`=0) with `rx_fc_en`=1 and the transmitter running, a received character equal to `stop_c1` while `tx_idle`=1 makes `tx_allow` 0 from the first clock edge after the character's `rx_valid` cycle.
- R3: If `tx_idle` is 0 when the stop match arrives, `tx_allow` stays 1 until the edge that samples `tx_idle`=1. It then drops at that edge.
- R4: In pair mode (`pair_mode`=1), a stop match needs `stop_c1` followed directly by `stop_c2` in consecutive received characters. Any other character breaks the partial match, and that same character is checked again as a possible `stop_c1`. The same rule applies to `start_c1`/`start_c2`.
- R5: While the transmitter is held or waiting to be held, a start match (`start_c1` in single mode, `start_c1` then `start_c2` in pair mode) sets `tx_allow` to 1 at the next edge. Stop characters received in that state are ignored.
- R6: An acted-on stop match sets `stop_irq` when `stop_irq_en`=1 and leaves it 0 when `stop_irq_en`=0. An acted-on start match clears it.
- R7: `fc_char` is 1 in the same cycle as `rx_valid` for exactly those characters that complete an acted-on stop or start match, and 0 otherwise.
- R8: With `tx_req_en`=1, `send_stop` pulses high for one cycle, one edge after `fifo_level` first reaches the upper mark. The upper mark is 4, 8, 12 or 14 for `trig_sel` values 0, 1, 2 and 3. There is one pulse per crossing, however long the level stays high.
- R9: `send_start` pulses for one cycle, one edge after `fifo_level` is at or below the lower mark, but only after a `send_stop` was issued. The lower mark is 1, 4, 8 or 10 for `trig_sel` values 0, 1, 2 and 3.
- R10: With `rx_fc_en`=0, received characters never change `tx_allow` and never raise `fc_char`. With `tx_req_en`=0, neither request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a received character is on rx_data |
| rx_data | input | 8 | Received character |
| stop_c1 | input | 8 | First (or only) stop character |
| stop_c2 | input | 8 | Second stop character in pair mode |
| start_c1 | input | 8 | First (or only) start character |
| start_c2 | input | 8 | Second start character in pair mode |
| pair_mode | input | 1 | 1: two-character patterns, 0: single character |
| rx_fc_en | input | 1 | Act on received stop/start characters |
| tx_req_en | input | 1 | Issue send requests from FIFO occupancy |
| stop_irq_en | input | 1 | Allow stop matches to set stop_irq |
| trig_sel | input | 2 | Selects the upper and lower FIFO marks |
| fifo_level | input | 5 | Receive FIFO occupancy, 0 to 16 |
| tx_idle | input | 1 | Serializer is between characters |
| tx_allow | output | 1 | Transmitter may start a new character |
| send_stop | output | 1 | One-cycle request to send a stop character |
| send_start | output | 1 | One-cycle request to send a start character |
| stop_irq | output | 1 | Far end has stopped the transmitter |
| fc_char | output | 1 | Current received character completed an acted-on match |

## Verification
`fc_char` is combinational, so the bench reads it one time step after it drives `rx_valid`, inside the same cycle. `tx_allow` and `stop_irq` come from one register each. The bench therefore reads them at the falling edge that follows the rising edge which took the character, or took `tx_idle`. `send_stop` and `send_start` also come from one register. The bench changes `fifo_level` at a falling edge and looks for the pulse at the next falling edge. It then looks again one cycle later and expects the pulse to be gone. All stimulus is applied at falling edges, so no check depends on the order of processes at a rising edge.

// File: rtl/xflow_pkg.sv
// Shared types and threshold tables for the Xon/Xoff flow controller.
// Assumes a 16-entry receive FIFO and a two-bit trigger selector.
package xflow_pkg;

    // Suspend state of the local transmitter
    typedef enum logic [1:0] {
        GATE_RUN   = 2'd0,
        GATE_DRAIN = 2'd1,
        GATE_HALT  = 2'd2
    } gate_state_t;

    // Occupancy at or above which a stop character is requested
    function automatic int unsigned upper_mark(input logic [1:0] sel);
        case (sel)
            2'd0:    return 4;
            2'd1:    return 8;
            2'd2:    return 12;
            default: return 14;
        endcase
    endfunction

    // Occupancy at or below which a start character is requested
    function automatic int unsigned lower_mark(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/xflow_match.sv
// Pattern matcher for one flow-control pattern (stop or start).
// Single mode: a hit is a received character equal to c1.
// Pair mode: a hit is c1 followed directly by c2. A broken partial
// match re-checks the breaking character as a new c1.
// Assumes rx_valid is a one-cycle strobe per character.
module xflow_match #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          pair_mode,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic [DW-1:0] c1,
    input  logic [DW-1:0] c2,
    output logic          hit
);
    logic armed;
    logic is_c1;
    logic is_c2;

    // Compare the current character with both pattern values
    always_comb begin
        is_c1 = (rx_data == c1);
        is_c2 = (rx_data == c2);
    end

    // Decide whether the current character completes the pattern
    always_comb begin
        if (!en || !rx_valid)
            hit = 1'b0;
        else if (pair_mode)
            hit = armed && is_c2;
        else
            hit = is_c1;
    end

    // Track a pending first character in pair mode
    always_ff @(posedge clk) begin
        if (!rst_n || !en || !pair_mode)
            armed <= 1'b0;
        else if (rx_valid)
            armed <= !hit && is_c1;
    end

    // R4
    // armed_src_chk: a partial match appears only after a first character arrives
    armed_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(rx_valid && rx_data == c1 && pair_mode));

endmodule

// File: rtl/xflow_gate.sv
// Transmit gate: suspends the transmitter on a stop match, only once the
// serializer is between characters, and resumes it on a start match.
// It also keeps the stop interrupt flag.
// Assumes the hits are already qualified by rx_valid.
module xflow_gate
    import xflow_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_fc_en,
    input  logic stop_hit,
    input  logic start_hit,
    input  logic tx_idle,
    input  logic irq_en,
    output logic tx_allow,
    output logic stop_irq,
    output logic act_char
);
    gate_state_t state, state_nx;
    logic        act_stop;
    logic        act_start;
    logic        flag_q;

    // Select which match is acted on in the present state
    always_comb begin
        act_stop  = rx_fc_en && (state == GATE_RUN) && stop_hit;
        act_start = rx_fc_en && (state != GATE_RUN) && start_hit;
        act_char  = act_stop || act_start;
    end

    // Next-state logic for the suspend machine
    always_comb begin
        state_nx = state;
        if (!rx_fc_en)
            state_nx = GATE_RUN;
        else begin
            case (state)
                GATE_RUN:   if (act_stop) state_nx = tx_idle ? GATE_HALT : GATE_DRAIN;
                GATE_DRAIN: if (act_start) state_nx = GATE_RUN;
                            else if (tx_idle) state_nx = GATE_HALT;
                GATE_HALT:  if (act_start) state_nx = GATE_RUN;
                default:    state_nx = GATE_RUN;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= GATE_RUN;
        else        state <= state_nx;
    end

    // Interrupt flag: set by an enabled stop match, cleared by a start match
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (act_start)
            flag_q <= 1'b0;
        else if (act_stop && irq_en)
            flag_q <= 1'b1;
    end

    assign tx_allow = (state != GATE_HALT);
    assign stop_irq = flag_q;

    // R3
    // halt_at_idle_chk: the transmitter is held only after an idle sample
    halt_at_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_allow) |-> $past(tx_idle));

    // R5
    // resume_on_start_chk: hold is released only by a start match or disable
    resume_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_allow) |-> $past(start_hit || !rx_fc_en));

    // R6
    // irq_enable_chk: the flag rises only when its enable was set
    irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_irq) |-> $past(irq_en && stop_hit));

endmodule

// File: rtl/xflow_txreq.sv
// Send-request generator: asks for a stop character when receive FIFO
// occupancy reaches the upper mark, and for a start character when it
// later drains to the lower mark. Each request is a one-cycle pulse.
// Assumes the upper mark is above the lower mark for every selector value.
module xflow_txreq
    import xflow_pkg::*;
#(
    parameter int unsigned LW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_en,
    input  logic [1:0]    trig_sel,
    input  logic [LW-1:0] level,
    output logic          send_stop,
    output logic          send_start
);
    logic        stop_sent;
    logic        want_stop;
    logic        want_start;
    int unsigned lvl;

    // Compare occupancy with the selected marks
    always_comb begin
        lvl        = int'(level);
        want_stop  = req_en && !stop_sent && (lvl >= upper_mark(trig_sel));
        want_start = req_en && stop_sent && (lvl <= lower_mark(trig_sel));
    end

    // Remember that a stop was requested and register the pulses
    always_ff @(posedge clk) begin
        if (!rst_n || !req_en) begin
            stop_sent  <= 1'b0;
            send_stop  <= 1'b0;
            send_start <= 1'b0;
        end else begin
            send_stop  <= want_stop;
            send_start <= want_start;
            if (want_stop)       stop_sent <= 1'b1;
            else if (want_start) stop_sent <= 1'b0;
        end
    end

    // R8
    // stop_once_chk: a stop request never lasts two cycles
    stop_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        send_stop |=> !send_stop);

    // R9
    // req_excl_chk: both requests are never raised together
    req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(send_stop && send_start));

endmodule

// File: rtl/xflow_ctrl.sv
// Top of the Xon/Xoff flow controller for one serial channel.
// It joins two pattern matchers (stop, start), the transmit gate and the
// send-request generator. Assumes a synchronous active-low reset.
module xflow_ctrl #(
    parameter int unsigned DW = 8,
    parameter int unsigned LW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic [DW-1:0] stop_c1,
    input  logic [DW-1:0] stop_c2,
    input  logic [DW-1:0] start_c1,
    input  logic [DW-1:0] start_c2,
    input  logic          pair_mode,
    input  logic          rx_fc_en,
    input  logic          tx_req_en,
    input  logic          stop_irq_en,
    input  logic [1:0]    trig_sel,
    input  logic [LW-1:0] fifo_level,
    input  logic          tx_idle,
    output logic          tx_allow,
    output logic          send_stop,
    output logic          send_start,
    output logic          stop_irq,
    output logic          fc_char
);
    localparam int unsigned NPAT = 2;

    logic [DW-1:0] pat_c1 [NPAT];
    logic [DW-1:0] pat_c2 [NPAT];
    logic [NPAT-1:0] pat_hit;

    // Gather the pattern values: index 0 stops, index 1 starts
    always_comb begin
        pat_c1[0] = stop_c1;
        pat_c2[0] = stop_c2;
        pat_c1[1] = start_c1;
        pat_c2[1] = start_c2;
    end

    for (genvar gi = 0; gi < NPAT; gi++) begin : g_pat
        xflow_match #(.DW(DW)) u_match (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (rx_fc_en),
            .pair_mode (pair_mode),
            .rx_valid  (rx_valid),
            .rx_data   (rx_data),
            .c1        (pat_c1[gi]),
            .c2        (pat_c2[gi]),
            .hit       (pat_hit[gi])
        );
    end

    xflow_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_fc_en  (rx_fc_en),
        .stop_hit  (pat_hit[0]),
        .start_hit (pat_hit[1]),
        .tx_idle   (tx_idle),
        .irq_en    (stop_irq_en),
        .tx_allow  (tx_allow),
        .stop_irq  (stop_irq),
        .act_char  (fc_char)
    );

    xflow_txreq #(.LW(LW)) u_txreq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_en     (tx_req_en),
        .trig_sel   (trig_sel),
        .level      (fifo_level),
        .send_stop  (send_stop),
        .send_start (send_start)
    );

    // R7
    // strobe_valid_chk: the match strobe appears only with a received character
    strobe_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fc_char |-> (rx_valid && rx_fc_en));

    // R10
    // disabled_run_chk: with receive matching off the transmitter is not held later
    disabled_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_fc_en |=> tx_allow);

endmodule

// File: tb/xflow_ctrl_bench.sv
module xflow_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic [7:0] stop_c1, stop_c2, start_c1, start_c2;
    logic       pair_mode, rx_fc_en, tx_req_en, stop_irq_en;
    logic [1:0] trig_sel;
    logic [4:0] fifo_level;
    logic       tx_idle;
    logic       tx_allow, send_stop, send_start, stop_irq, fc_char;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    xflow_ctrl u_xflow_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .stop_c1(stop_c1), .stop_c2(stop_c2), .start_c1(start_c1), .start_c2(start_c2),
        .pair_mode(pair_mode), .rx_fc_en(rx_fc_en), .tx_req_en(tx_req_en),
        .stop_irq_en(stop_irq_en), .trig_sel(trig_sel), .fifo_level(fifo_level),
        .tx_idle(tx_idle), .tx_allow(tx_allow), .send_stop(send_stop),
        .send_start(send_start), .stop_irq(stop_irq), .fc_char(fc_char)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // Present one character for one cycle; check the same-cycle strobe
    task automatic rx_char(input logic [7:0] d, input logic exp_strobe, input string req);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = d;
        #1;
        check(req, "fc_char", fc_char, exp_strobe);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1", "tx_allow", tx_allow, 1'b1);
        check("R1", "send_stop", send_stop, 1'b0);
        check("R1", "send_start", send_start, 1'b0);
        check("R1", "stop_irq", stop_irq, 1'b0);
    endtask

    task automatic t_single();
        pair_mode = 0; rx_fc_en = 1; stop_irq_en = 1; tx_idle = 1;
        rx_char(8'h41, 1'b0, "R7");
        check("R2", "tx_allow plain char", tx_allow, 1'b1);
        rx_char(8'h13, 1'b1, "R7");
        check("R2", "tx_allow after stop", tx_allow, 1'b0);
        check("R6", "stop_irq set", stop_irq, 1'b1);
        rx_char(8'h13, 1'b0, "R5");
        check("R5", "stop while held ignored", tx_allow, 1'b0);
        rx_char(8'h11, 1'b1, "R7");
        check("R5", "tx_allow after start", tx_allow, 1'b1);
        check("R6", "stop_irq cleared", stop_irq, 1'b0);
        rx_char(8'h11, 1'b0, "R7");
        check("R5", "start while running", tx_allow, 1'b1);
    endtask

    task automatic t_drain();
        tx_idle = 0;
        rx_char(8'h13, 1'b1, "R3");
        check("R3", "busy keeps tx_allow", tx_allow, 1'b1);
        repeat (3) @(negedge clk);
        check("R3", "still busy", tx_allow, 1'b1);
        tx_idle = 1;
        @(negedge clk);
        check("R3", "held after idle", tx_allow, 1'b0);
        rx_char(8'h11, 1'b1, "R5");
        check("R5", "resume after drain", tx_allow, 1'b1);
        tx_idle = 0;
        rx_char(8'h13, 1'b1, "R3");
        rx_char(8'h11, 1'b1, "R5");
        tx_idle = 1;
        @(negedge clk);
        check("R5", "start cancels pending hold", tx_allow, 1'b1);
    endtask

    task automatic t_pair();
        pair_mode = 1;
        stop_c1 = 8'hA1; stop_c2 = 8'hA2; start_c1 = 8'hB1; start_c2 = 8'hB2;
        rx_char(8'hA1, 1'b0, "R4");
        check("R4", "first char only", tx_allow, 1'b1);
        rx_char(8'hA2, 1'b1, "R4");
        check("R4", "pair stop", tx_allow, 1'b0);
        rx_char(8'hB1, 1'b0, "R4");
        check("R4", "half start", tx_allow, 1'b0);
        rx_char(8'hB2, 1'b1, "R4");
        check("R4", "pair start", tx_allow, 1'b1);
        rx_char(8'hA1, 1'b0, "R4");
        rx_char(8'h55, 1'b0, "R4");
        rx_char(8'hA2, 1'b0, "R4");
        check("R4", "broken pair", tx_allow, 1'b1);
        rx_char(8'hA1, 1'b0, "R4");
        rx_char(8'hA1, 1'b0, "R4");
        rx_char(8'hA2, 1'b1, "R4");
        check("R4", "recheck as first", tx_allow, 1'b0);
        rx_char(8'hB1, 1'b0, "R4");
        rx_char(8'hB2, 1'b1, "R4");
        check("R4", "resume", tx_allow, 1'b1);
        pair_mode = 0;
        stop_c1 = 8'h13; start_c1 = 8'h11;
    endtask

    task automatic t_irq_off();
        stop_irq_en = 0;
        rx_char(8'h13, 1'b1, "R6");
        check("R6", "held", tx_allow, 1'b0);
        check("R6", "irq masked", stop_irq, 1'b0);
        rx_char(8'h11, 1'b1, "R6");
        stop_irq_en = 1;
    endtask

    task automatic t_fc_off();
        rx_fc_en = 0;
        rx_char(8'h13, 1'b0, "R10");
        check("R10", "disabled stop ignored", tx_allow, 1'b1);
        check("R10", "no irq", stop_irq, 1'b0);
        rx_fc_en = 1;
    endtask

    // Ramp occupancy for one selector value and look for both pulses
    task automatic t_req(input logic [1:0] sel, input int up, input int lo);
        trig_sel = sel; tx_req_en = 1;
        @(negedge clk);
        fifo_level = 5'(lo);
        @(negedge clk);
        check("R9", "no start before stop", send_start, 1'b0);
        fifo_level = 5'(up - 1);
        @(negedge clk);
        check("R8", "below upper mark", send_stop, 1'b0);
        fifo_level = 5'(up);
        @(negedge clk);
        check("R8", "stop pulse at mark", send_stop, 1'b1);
        @(negedge clk);
        check("R8", "stop pulse once", send_stop, 1'b0);
        fifo_level = 5'(16);
        repeat (2) @(negedge clk);
        check("R8", "no repeat while high", send_stop, 1'b0);
        fifo_level = 5'(lo + 1);
        @(negedge clk);
        check("R9", "above lower mark", send_start, 1'b0);
        fifo_level = 5'(lo);
        @(negedge clk);
        check("R9", "start pulse at mark", send_start, 1'b1);
        @(negedge clk);
        check("R9", "start pulse once", send_start, 1'b0);
        fifo_level = 5'(0);
        @(negedge clk);
    endtask

    task automatic t_req_off();
        tx_req_en = 0;
        fifo_level = 5'(16);
        repeat (2) @(negedge clk);
        check("R10", "no stop request when off", send_stop, 1'b0);
        fifo_level = 5'(0);
        @(negedge clk);
        check("R10", "no start request when off", send_start, 1'b0);
    endtask

    initial begin
        rst_n = 0; rx_valid = 0; rx_data = 0;
        stop_c1 = 8'h13; stop_c2 = 8'h00; start_c1 = 8'h11; start_c2 = 8'h00;
        pair_mode = 0; rx_fc_en = 0; tx_req_en = 0; stop_irq_en = 0;
        trig_sel = 0; fifo_level = 0; tx_idle = 1;
        t_reset();
        t_single();
        t_drain();
        t_pair();
        t_irq_off();
        t_fc_off();
        t_req(2'd0, 4, 1);
        t_req(2'd1, 8, 4);
        t_req(2'd2, 12, 8);
        t_req(2'd3, 14, 10);
        t_req_off();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule